// File: doc/BRIEF.md
# Early-Terminating Multiply-Accumulate Unit

This unit is the multi-cycle integer multiplier of a 32-bit processor core. It takes a multiplicand and a multiplier, and an optional accumulate value. It produces either a 32-bit result (short form) or a 64-bit result split into a low and a high word (long form). The long form can be signed or unsigned. When set-flags is requested, the negative and zero condition flags are recomputed from the result. The carry and overflow flags always pass through unchanged.

The multiplier operand is consumed one byte per internal cycle, least significant byte first. The unit stops as soon as the remaining upper bytes carry no information. The total latency therefore depends on the data: one setup cycle, plus one cycle per significant multiplier byte, plus one cycle each for the long form and for accumulation. A `start` strobe launches an operation. `busy` stays high for exactly that many cycles, then `done` pulses for one cycle, with the results and the cycle count held on the outputs.

Top module: `mac_early_term`

## Requirements
- R1: In the short form (`op_long`=0), `res_lo` equals the low 32 bits of `mcand`*`mplier`, plus `acc_lo` when `op_acc`=1. `res_hi` is 0.
- R2: In the long form (`op_long`=1), {`res_hi`,`res_lo`} is the 64-bit product. Both operands are two's complement when `op_signed`=1 and unsigned when `op_signed`=0.
- R3: A long accumulate adds the 64-bit value {`acc_hi`,`acc_lo`} to the product, with `acc_hi` as the upper word.
- R4: The significant byte count m is the smallest j in 1..3 for which multiplier bits 31:8j are all zero, or all one when sign-extension applies, and 4 otherwise. Sign-extension applies in the short form and in the signed long form, but not in the unsigned long form. `cyc_count` reports 1 + m + `op_long` + `op_acc`.
- R5: After `start` is sampled while idle, `busy` is high for exactly `cyc_count` cycles. `done` is then high for one cycle, with `busy` low.
- R6: With `op_setf`=1, `nzcv_out` bit 3 (N) is the result's top bit: bit 63 for the long form, bit 31 for the short form. Bit 2 (Z) is 1 only when the whole 64-bit (long) or 32-bit (short) result is zero.
- R7: `nzcv_out` bits 1:0 (C, V) always equal `nzcv_in` bits 1:0 as sampled at `start`. With `op_setf`=0, all four bits equal `nzcv_in`.
- R8: A `start` while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R9: After reset, `busy`, `done`, `res_lo`, `res_hi`, `nzcv_out` and `cyc_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch strobe, accepted only while idle |
| op_long | input | 1 | 1 selects the 64-bit result form |
| op_signed | input | 1 | Two's complement operands for the long form |
| op_acc | input | 1 | Add the accumulate value |
| op_setf | input | 1 | Recompute N and Z |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier (controls early termination) |
| acc_lo | input | 32 | Accumulate low word |
| acc_hi | input | 32 | Accumulate high word (long form only) |
| nzcv_in | input | 4 | Current flags N,Z,C,V in bits 3..0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word (0 in short form) |
| nzcv_out | output | 4 | Updated flags N,Z,C,V in bits 3..0 |
| cyc_count | output | 3 | Cycles taken by the last operation |

## Verification
The hardest case to reach is the last-byte sign correction. It arises when the upper multiplier bytes are all ones but the top bit of the last processed byte is zero, as in 0xFFFFFF05. Here the multiplier is a small negative number whose remaining byte is not itself a valid signed byte. Running the same pattern through the unsigned long form must also disable early termination. The bench sweeps a list of multiplier patterns that hits every m value with both zero and one extensions, including those boundary bytes. It runs each pattern against several multiplicands under all sixteen control combinations, and computes products, flags and latencies arithmetically. Dedicated cases place a zero only in the low word, and inject a second start in the middle of an operation.

// File: rtl/mac_et_pkg.sv
// Package: shared control type for the early-terminating multiply unit.
package mac_et_pkg;

    // Operation controls captured with each start strobe.
    typedef struct packed {
        logic long_f;    // 64-bit result form
        logic signed_f;  // two's complement (long form)
        logic acc_f;     // add accumulate value
        logic setf_f;    // recompute N and Z
    } op_ctrl_t;

    // Whether an all-ones multiplier top counts as insignificant.
    function automatic logic ext_mode(input op_ctrl_t c);
        return c.long_f ? c.signed_f : 1'b1;
    endfunction

endpackage

// File: rtl/mac_et_span.sv
// mac_et_span: counts the significant multiplier chunks (m).
// Assumes XLEN is a multiple of CHUNK. Purely combinational.
module mac_et_span #(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8,
    localparam int NCHUNK = XLEN / CHUNK,
    localparam int MW     = $clog2(NCHUNK + 1)
) (
    input  logic [XLEN-1:0] mplier,
    input  logic            sign_ext_ok,
    output logic [MW-1:0]   m
);

    logic [NCHUNK-1:0] fits;

    assign fits[0] = 1'b0;

    // One detector per possible cut point: upper bits all zero or all one.
    for (genvar j = 1; j < NCHUNK; j++) begin : g_cut
        logic up_zero;
        logic up_ones;
        assign up_zero = ~|mplier[XLEN-1:j*CHUNK];
        assign up_ones = &mplier[XLEN-1:j*CHUNK];
        assign fits[j] = up_zero | (sign_ext_ok & up_ones);
    end

    // Pick the smallest cut point that fits, else all chunks.
    always_comb begin
        m = MW'(NCHUNK);
        for (int j = NCHUNK - 1; j >= 1; j--) begin
            if (fits[j]) m = MW'(j);
        end
    end

endmodule

// File: rtl/mac_et_seq.sv
// mac_et_seq: cycle sequencer. Holds busy for the requested number of
// cycles, exposes the running cycle index, and pulses done at the end.
// Assumes total_in >= 2 whenever accept is high.
module mac_et_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] total_in,
    output logic             busy,
    output logic             done,
    output logic             finish,
    output logic [CNT_W-1:0] k,
    output logic [CNT_W-1:0] cyc_count
);

    logic [CNT_W-1:0] total_q;

    // Last busy cycle of the current operation.
    assign finish = busy && (k == total_q - CNT_W'(1));

    // Cycle counter, busy/done handshake and reported cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            k         <= '0;
            total_q   <= '0;
            cyc_count <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                k       <= '0;
                total_q <= total_in;
            end else if (busy) begin
                if (finish) begin
                    busy      <= 1'b0;
                    done      <= 1'b1;
                    cyc_count <= total_q;
                end else begin
                    k <= k + CNT_W'(1);
                end
            end
        end
    end

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_ends_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (k < total_q));
    assert_total_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish |=> busy && $stable(total_q));

endmodule

// File: rtl/mac_et_dp.sv
// mac_et_dp: datapath. Latches operands at accept, adds one signed
// partial product per chunk step, and registers results and flags at finish.
// Assumes the step indices arrive as 0..m-1 while step_en is high.
module mac_et_dp
    import mac_et_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8,
    parameter int CNT_W = 3,
    localparam int NCHUNK = XLEN / CHUNK,
    localparam int MW     = $clog2(NCHUNK + 1),
    localparam int IDXW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int ACCW   = 2 * XLEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  op_ctrl_t         ctrl,
    input  logic [XLEN-1:0]  mcand,
    input  logic [XLEN-1:0]  mplier,
    input  logic [XLEN-1:0]  acc_lo,
    input  logic [XLEN-1:0]  acc_hi,
    input  logic [3:0]       nzcv_in,
    input  logic [MW-1:0]    m_in,
    input  logic             busy,
    input  logic             finish,
    input  logic [CNT_W-1:0] k,
    output logic [XLEN-1:0]  res_lo,
    output logic [XLEN-1:0]  res_hi,
    output logic [3:0]       nzcv_out
);

    logic [ACCW-1:0] a_q;
    logic [XLEN-1:0] b_q;
    logic [MW-1:0]   m_q;
    logic            long_q;
    logic            ext_q;
    logic            setf_q;
    logic [3:0]      flags_q;
    logic [ACCW-1:0] prod_q;

    logic            step_en;
    logic            step_last;
    logic [IDXW-1:0] idx;
    logic [CHUNK-1:0] chunk;
    logic            top_ext;
    logic [ACCW-1:0] fac_w;
    logic [ACCW-1:0] pp;
    logic [ACCW-1:0] a_init;
    logic [ACCW-1:0] acc_init;

    // Multiplicand widened per form, accumulate value per form.
    always_comb begin
        a_init = (ctrl.long_f && ctrl.signed_f) ? {{XLEN{mcand[XLEN-1]}}, mcand}
                                                : {{XLEN{1'b0}}, mcand};
        if (!ctrl.acc_f)
            acc_init = '0;
        else if (ctrl.long_f)
            acc_init = {acc_hi, acc_lo};
        else
            acc_init = {{XLEN{1'b0}}, acc_lo};
    end

    // Step control: chunk select and the sign weight of the last chunk.
    assign step_en   = busy && (k < CNT_W'(m_q));
    assign step_last = (k == CNT_W'(m_q) - CNT_W'(1));
    assign idx       = k[IDXW-1:0];
    assign chunk     = b_q[idx*CHUNK +: CHUNK];
    assign top_ext   = step_last & ext_q & b_q[XLEN-1];

    // Signed chunk factor {ext, chunk} widened, and its shifted partial product.
    assign fac_w = {{(ACCW-CHUNK-1){top_ext}}, top_ext, chunk};
    assign pp    = (a_q * fac_w) << (idx * CHUNK);

    // Operand capture and accumulation of partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            m_q     <= '0;
            long_q  <= 1'b0;
            ext_q   <= 1'b0;
            setf_q  <= 1'b0;
            flags_q <= '0;
            prod_q  <= '0;
        end else if (accept) begin
            a_q     <= a_init;
            b_q     <= mplier;
            m_q     <= m_in;
            long_q  <= ctrl.long_f;
            ext_q   <= ext_mode(ctrl);
            setf_q  <= ctrl.setf_f;
            flags_q <= nzcv_in;
            prod_q  <= acc_init;
        end else if (step_en) begin
            prod_q  <= prod_q + pp;
        end
    end

    // Result words and flags registered on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo   <= '0;
            res_hi   <= '0;
            nzcv_out <= '0;
        end else if (finish) begin
            res_lo <= prod_q[XLEN-1:0];
            res_hi <= long_q ? prod_q[ACCW-1:XLEN] : '0;
            nzcv_out[1:0] <= flags_q[1:0];
            if (setf_q) begin
                nzcv_out[3] <= long_q ? prod_q[ACCW-1] : prod_q[XLEN-1];
                nzcv_out[2] <= long_q ? (prod_q == '0) : (prod_q[XLEN-1:0] == '0);
            end else begin
                nzcv_out[3:2] <= flags_q[3:2];
            end
        end
    end

    assert_short_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        finish && !long_q |=> res_hi == '0);
    assert_cv_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> nzcv_out[1:0] == $past(flags_q[1:0]));
    assert_zero_flag_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish && setf_q && long_q |=> nzcv_out[2] == ({res_hi, res_lo} == '0));
    assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish |=> $stable(a_q) && $stable(b_q) && $stable(m_q));
    assert_m_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (m_q >= MW'(1)) && (m_q <= MW'(NCHUNK)));

endmodule

// File: rtl/mac_early_term.sv
// mac_early_term: top of the early-terminating multiply-accumulate unit.
// Accepts an operation on start while idle. Latency is 1 + m + long + acc.
module mac_early_term
    import mac_et_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8,
    localparam int NCHUNK = XLEN / CHUNK,
    localparam int MW     = $clog2(NCHUNK + 1),
    localparam int CNT_W  = $clog2(NCHUNK + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_long,
    input  logic             op_signed,
    input  logic             op_acc,
    input  logic             op_setf,
    input  logic [XLEN-1:0]  mcand,
    input  logic [XLEN-1:0]  mplier,
    input  logic [XLEN-1:0]  acc_lo,
    input  logic [XLEN-1:0]  acc_hi,
    input  logic [3:0]       nzcv_in,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  res_lo,
    output logic [XLEN-1:0]  res_hi,
    output logic [3:0]       nzcv_out,
    output logic [CNT_W-1:0] cyc_count
);

    op_ctrl_t         ctrl;
    logic             accept;
    logic [MW-1:0]    m_now;
    logic [CNT_W-1:0] total_now;
    logic             finish;
    logic [CNT_W-1:0] k;

    // Pack controls and gate start with idle.
    assign ctrl   = '{long_f: op_long, signed_f: op_signed, acc_f: op_acc, setf_f: op_setf};
    assign accept = start && !busy;

    // Total cycles: setup + m steps + long extra + accumulate extra.
    assign total_now = CNT_W'(1) + CNT_W'(m_now) + CNT_W'(op_long) + CNT_W'(op_acc);

    mac_et_span #(.XLEN(XLEN), .CHUNK(CHUNK)) u_span (
        .mplier      (mplier),
        .sign_ext_ok (ext_mode(ctrl)),
        .m           (m_now)
    );

    mac_et_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .total_in  (total_now),
        .busy      (busy),
        .done      (done),
        .finish    (finish),
        .k         (k),
        .cyc_count (cyc_count)
    );

    mac_et_dp #(.XLEN(XLEN), .CHUNK(CHUNK), .CNT_W(CNT_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .ctrl     (ctrl),
        .mcand    (mcand),
        .mplier   (mplier),
        .acc_lo   (acc_lo),
        .acc_hi   (acc_hi),
        .nzcv_in  (nzcv_in),
        .m_in     (m_now),
        .busy     (busy),
        .finish   (finish),
        .k        (k),
        .res_lo   (res_lo),
        .res_hi   (res_hi),
        .nzcv_out (nzcv_out)
    );

    assert_latency_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_count >= CNT_W'(2)) && (cyc_count <= CNT_W'(NCHUNK + 3)));
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/mac_early_term_tb.sv
// Bench for mac_early_term: sweeps multiplier patterns, multiplicands and
// all control combinations; expected values are computed arithmetically.
module mac_early_term_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_long = 1'b0, op_signed = 1'b0, op_acc = 1'b0, op_setf = 1'b0;
    logic [31:0] mcand = '0, mplier = '0, acc_lo = '0, acc_hi = '0;
    logic [3:0]  nzcv_in = '0;
    logic        busy, done;
    logic [31:0] res_lo, res_hi;
    logic [3:0]  nzcv_out;
    logic [2:0]  cyc_count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mac_early_term u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_long(op_long), .op_signed(op_signed), .op_acc(op_acc), .op_setf(op_setf),
        .mcand(mcand), .mplier(mplier), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .nzcv_in(nzcv_in), .busy(busy), .done(done), .res_lo(res_lo),
        .res_hi(res_hi), .nzcv_out(nzcv_out), .cyc_count(cyc_count)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_m(input logic [31:0] b, input bit ext_ok);
        int m = 4;
        for (int j = 3; j >= 1; j--) begin
            logic [31:0] up = b >> (8 * j);
            logic [31:0] ones = (32'h1 << (32 - 8 * j)) - 32'h1;
            if (up == 32'h0 || (ext_ok && up == ones)) m = j;
        end
        return m;
    endfunction

    task automatic expect_op(input logic [31:0] a, b, alo, ahi, input logic [3:0] nz,
                             input bit lng, sgn, acc, setf,
                             output logic [31:0] elo, ehi, output logic [3:0] enz,
                             output int ecyc);
        logic [63:0] ae, be, p;
        logic [31:0] p32;
        bit n, z;
        if (lng) begin
            ae = sgn ? {{32{a[31]}}, a} : {32'h0, a};
            be = sgn ? {{32{b[31]}}, b} : {32'h0, b};
            p = ae * be;
            if (acc) p = p + {ahi, alo};
            elo = p[31:0]; ehi = p[63:32];
            n = p[63]; z = (p == 64'h0);
        end else begin
            p32 = a * b;
            if (acc) p32 = p32 + alo;
            elo = p32; ehi = 32'h0;
            n = p32[31]; z = (p32 == 32'h0);
        end
        enz = setf ? {n, z, nz[1:0]} : nz;
        ecyc = 1 + exp_m(b, lng ? sgn : 1'b1) + int'(lng) + int'(acc);
    endtask

    task automatic check_results(input string rtag, input logic [31:0] elo, ehi,
                                 input logic [3:0] enz, input int ecyc, input int meas);
        chk(res_lo == elo, rtag, "res_lo", res_lo, elo);
        chk(res_hi == ehi, rtag, "res_hi", res_hi, ehi);
        chk(nzcv_out[3:2] == enz[3:2], "R6", "nz", nzcv_out[3:2], enz[3:2]);
        chk(nzcv_out[1:0] == enz[1:0], "R7", "cv", nzcv_out[1:0], enz[1:0]);
        chk(int'(cyc_count) == ecyc, "R4", "cyc_count", cyc_count, ecyc);
        chk(meas == ecyc, "R5", "busy_len", meas, ecyc);
        chk(!busy, "R5", "busy_at_done", busy, 0);
    endtask

    task automatic run_op(input logic [31:0] a, b, alo, ahi, input logic [3:0] nz,
                          input bit lng, sgn, acc, setf, input bit inject);
        logic [31:0] elo, ehi;
        logic [3:0]  enz;
        int ecyc, n;
        string rtag;
        expect_op(a, b, alo, ahi, nz, lng, sgn, acc, setf, elo, ehi, enz, ecyc);
        rtag = lng ? (acc ? "R3" : "R2") : "R1";
        @(negedge clk);
        mcand = a; mplier = b; acc_lo = alo; acc_hi = ahi; nzcv_in = nz;
        op_long = lng; op_signed = sgn; op_acc = acc; op_setf = setf; start = 1'b1;
        @(negedge clk);
        start = 1'b0; n = 1;
        if (inject) begin
            // R8: second start while busy with different operands
            @(negedge clk); n++;
            mcand = ~a; mplier = 32'h7FFF_FFFF; acc_lo = 32'h1234_5678; nzcv_in = ~nz;
            op_long = ~lng; op_acc = ~acc; start = 1'b1;
            @(negedge clk); n++;
            start = 1'b0;
            chk(busy || done, "R8", "busy_kept", busy, 1);
        end
        while (!done && n < 40) begin
            @(negedge clk); n++;
        end
        check_results(inject ? "R8" : rtag, elo, ehi, enz, ecyc, n - 1);
        @(negedge clk);
        chk(!done, "R5", "done_one_cycle", done, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] blist [12];
        logic [31:0] alist [4];
        blist = '{32'h0000_005A, 32'h0000_00C3, 32'h0000_9A17, 32'h00A5_0001,
                  32'h7F00_0003, 32'hFFFF_FF85, 32'hFFFF_FF05, 32'hFFFF_8100,
                  32'hFF80_0000, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF};
        alist = '{32'h0DFF_A25D, 32'hFFFF_FFFF, 32'h8000_0001, 32'h0001_E7E1};

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R9", "ctl", {busy, done}, 0);
        chk(res_lo == 0 && res_hi == 0, "R9", "res", {res_hi, res_lo}, 0);
        chk(nzcv_out == 0 && cyc_count == 0, "R9", "flags_cyc", {nzcv_out, cyc_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R9", "idle_after_reset", {busy, done}, 0);

        // Sweep: all control combinations, patterns and multiplicands (R1..R7)
        for (int c = 0; c < 16; c++) begin
            for (int bi = 0; bi < 12; bi++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    run_op(alist[ai], blist[bi], 32'h0001_869F, 32'hE58C_2AB1,
                           4'((c + bi + ai) & 15), c[3], c[2], c[1], c[0], 1'b0);
                end
            end
        end

        // R6: zero only in the low word; long is nonzero, short is zero
        run_op(32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 4'b0111, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op(32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 4'b0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        // R3: accumulate cancels the product to zero
        run_op(32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 4'b1010,
               1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        // R8: start while busy is ignored
        run_op(32'h0DFF_A25D, 32'h0001_E7E1, 32'h0001_869F, 32'hE58C_2AB1, 4'b0110,
               1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        run_op(32'hCAFE_0001, 32'h0000_0011, 32'h0000_0005, 32'h0, 4'b1001,
               1'b0, 1'b0, 1'b1, 1'b0, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule